// File: doc/BRIEF.md
# Power-Fail Reset Supervisor

This block watches two digitised supply flags produced by external comparators. One flag says the supply is above the operating threshold. The other says it is above the lower switchover level. From these flags the block drives three things: a system reset with an open-drain style output, a write-protect for the attached memory, and a select that picks the battery as the retention source.

When the supply leaves tolerance, reset and write-protect are raised at once. When the supply recovers, both stay raised for a fixed count of clock cycles. They are released only if the supply stays in tolerance for the whole count. Any dropout during the count sends the block back to waiting, and the count starts again from zero.

Battery selection is a separate stage that follows the lower comparator alone. At the moment of release the block gives a one-cycle pulse, which other logic can use as a "recovery complete" marker. Both comparator flags pass through a synchroniser of `SYNC_STAGES` flops before any decision is made.

Top module: `pwr_fail_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_pull` = 1, `wr_prot` = 1, `recov_pulse` = 0 and `bat_sel` = 1.
- R2: Once `vop_ok` falls, `rst_pull` is 1 after exactly `SYNC_STAGES` rising clock edges. It is still 0 after `SYNC_STAGES`-1 edges if the block was released before.
- R3: After `vop_ok` rises from the powered-down state and stays high, `rst_pull` stays 1 through edge `SYNC_STAGES+HOLD_CYCLES`. It reads 0 after edge `SYNC_STAGES+1+HOLD_CYCLES`.
- R4: If `vop_ok` drops at any point during the hold, no release occurs. The full delay of R3 is measured again from the next rise of `vop_ok`.
- R5: `recov_pulse` is 1 for exactly the one cycle in which `rst_pull` first reads 0 after a hold. It is 0 at every other time.
- R6: `bat_sel` equals the inverse of `vsw_ok`, delayed by `SYNC_STAGES` edges. It does not depend on `vop_ok`.
- R7: `wr_prot` is 1 exactly when `rst_pull` is 1. Write-protect is never released while the synchronised `vop_ok` is low.
- R8: `rst_od_n` is driven to 0 while `rst_pull` is 1 and is left undriven (high-impedance) otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low initialisation of all state |
| vop_ok | input | 1 | Comparator flag: supply above operating threshold (asynchronous) |
| vsw_ok | input | 1 | Comparator flag: supply above switchover level (asynchronous) |
| rst_pull | output | 1 | 1 = reset pull-down active |
| rst_od_n | output | 1 | Open-drain reset pin: 0 or high-impedance |
| wr_prot | output | 1 | 1 = memory writes blocked |
| bat_sel | output | 1 | 1 = retention from battery, 0 = from external supply |
| recov_pulse | output | 1 | One-cycle marker at the end of the power-on hold |

## Verification
The assertions assume that the two comparators are ordered. The operating threshold lies above the switchover level, so a synchronised "above operating" flag never appears while the "above switchover" flag is low. The stimulus respects this ordering. It lowers both flags together or the operating flag first, and on the way up it raises the switchover flag before the operating flag. The inputs change only on the falling clock edge, which keeps the synchroniser latency exact so that the edge counts in R2, R3 and R6 can be checked precisely.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [1:0] {
        PS_DOWN = 2'd0,
        PS_HOLD = 2'd1,
        PS_UP   = 2'd2
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e st;
        logic       pulse;
    } sup_regs_t;

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pfs_hold_timer.sv
module pfs_hold_timer #(
    parameter int HOLD_CYCLES = 200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run)                 tmr_d.cnt = '0;
        else if (tmr_q.cnt != LAST) tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign done = run && (tmr_q.cnt == LAST);

    // R3: count never passes the hold limit
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST);

    // R4: a stopped timer restarts from zero
    a_r4_clear_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> tmr_q.cnt == '0);

endmodule

// File: rtl/pwr_fail_supervisor.sv
module pwr_fail_supervisor
    import pfs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vop_ok,
    input  logic vsw_ok,
    output logic rst_pull,
    output wire  rst_od_n,
    output logic wr_prot,
    output logic bat_sel,
    output logic recov_pulse
);

    logic      vop_s;
    logic      vsw_s;
    logic      hold_run;
    logic      hold_done;
    sup_regs_t sup_d, sup_q;

    pfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_op (
        .clk(clk), .rst_n(rst_n), .d(vop_ok), .q(vop_s)
    );

    pfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sw (
        .clk(clk), .rst_n(rst_n), .d(vsw_ok), .q(vsw_s)
    );

    assign hold_run = (sup_q.st == PS_HOLD) && vop_s;

    pfs_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(hold_run), .done(hold_done)
    );

    always_comb begin
        sup_d       = sup_q;
        sup_d.pulse = 1'b0;
        case (sup_q.st)
            PS_DOWN: if (vop_s) sup_d.st = PS_HOLD;
            PS_HOLD: begin
                if (!vop_s) begin
                    sup_d.st = PS_DOWN;
                end else if (hold_done) begin
                    sup_d.st    = PS_UP;
                    sup_d.pulse = 1'b1;
                end
            end
            PS_UP:   if (!vop_s) sup_d.st = PS_DOWN;
            default: sup_d.st = PS_DOWN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sup_q <= '{st: PS_DOWN, pulse: 1'b0};
        else        sup_q <= sup_d;
    end

    assign rst_pull    = (sup_q.st != PS_UP) || !vop_s;
    assign wr_prot     = !((sup_q.st == PS_UP) && vop_s);
    assign bat_sel     = !vsw_s;
    assign recov_pulse = sup_q.pulse;
    assign rst_od_n    = rst_pull ? 1'b0 : 1'bz;

    // input ordering the checks rely on: operating threshold above switchover
    a_in_threshold_order: assert property (@(posedge clk) disable iff (!rst_n)
        vop_s |-> vsw_s);

    // R2: supply loss forces reset
    a_r2_loss_resets: assert property (@(posedge clk) disable iff (!rst_n)
        !vop_s |-> rst_pull);

    // R7: supply loss forces write-protect
    a_r7_loss_protects: assert property (@(posedge clk) disable iff (!rst_n)
        !vop_s |-> wr_prot);

    // R5: the recovery marker lasts one cycle
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        recov_pulse |=> !recov_pulse);

    // R5: release from a hold coincides with the marker
    a_r5_pulse_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pull) |-> recov_pulse);

    // R4: a dropout during the hold returns to the waiting state
    a_r4_hold_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_q.st == PS_HOLD && !vop_s) |=> sup_q.st == PS_DOWN);

endmodule

// File: tb/tb_pwr_fail_supervisor.sv
module tb_pwr_fail_supervisor;

    localparam int SYNC = 2;
    localparam int HOLD = 20;
    localparam int LAT  = SYNC + 1 + HOLD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vop_ok = 1'b0;
    logic vsw_ok = 1'b0;
    logic rst_pull, wr_prot, bat_sel, recov_pulse;
    wire  rst_od_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_fail_supervisor #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .vop_ok(vop_ok), .vsw_ok(vsw_ok),
        .rst_pull(rst_pull), .rst_od_n(rst_od_n), .wr_prot(wr_prot),
        .bat_sel(bat_sel), .recov_pulse(recov_pulse)
    );

    task automatic check(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // advance n rising edges, then sample 1 ns later
    task automatic edges(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic drive(logic op, logic sw);
        @(negedge clk);
        vop_ok = op;
        vsw_ok = sw;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #23;
        check("R1 rst_pull", rst_pull, 1'b1);
        check("R1 wr_prot", wr_prot, 1'b1);
        check("R1 recov_pulse", recov_pulse, 1'b0);
        check("R1 bat_sel", bat_sel, 1'b1);
        check("R8 pin low in reset", rst_od_n, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        edges(4);
    endtask

    // rise of vop from the down state; checks exact release cycle
    task automatic t_powerup(string tag);
        drive(1'b1, 1'b1);
        edges(LAT - 1);
        check({tag, " R3 held before release"}, rst_pull, 1'b1);
        check({tag, " R7 wp held"}, wr_prot, 1'b1);
        check({tag, " R5 no early pulse"}, recov_pulse, 1'b0);
        edges(1);
        check({tag, " R3 released"}, rst_pull, 1'b0);
        check({tag, " R7 wp released"}, wr_prot, 1'b0);
        check({tag, " R5 pulse at release"}, recov_pulse, 1'b1);
        edges(1);
        check({tag, " R5 pulse one cycle"}, recov_pulse, 1'b0);
        check({tag, " R3 stays released"}, rst_pull, 1'b0);
    endtask

    task automatic t_loss();
        drive(1'b0, 1'b1);
        edges(SYNC - 1);
        check("R2 not yet asserted", rst_pull, 1'b0);
        edges(1);
        check("R2 asserted after sync", rst_pull, 1'b1);
        check("R7 wp on loss", wr_prot, 1'b1);
        check("R8 pin low on loss", rst_od_n, 1'b0);
        check("R6 bat_sel unaffected by vop", bat_sel, 1'b0);
        edges(3);
    endtask

    task automatic t_glitch();
        bit saw_release = 1'b0;
        drive(1'b1, 1'b1);
        edges(10);
        drive(1'b0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            edges(1);
            if (!rst_pull || recov_pulse) saw_release = 1'b1;
        end
        check("R4 no release during dropout", saw_release, 1'b0);
        t_powerup("glitch");
    endtask

    task automatic t_battery();
        drive(1'b0, 1'b1);
        edges(4);
        drive(1'b0, 1'b0);
        edges(SYNC - 1);
        check("R6 bat_sel before sync", bat_sel, 1'b0);
        edges(1);
        check("R6 battery selected", bat_sel, 1'b1);
        check("R2 reset while down", rst_pull, 1'b1);
        drive(1'b0, 1'b1);
        edges(SYNC);
        check("R6 external selected", bat_sel, 1'b0);
        check("R7 wp held with vop low", wr_prot, 1'b1);
        edges(5);
        check("R3 no release without vop", rst_pull, 1'b1);
    endtask

    initial begin
        t_reset();
        t_powerup("first");
        t_loss();
        t_glitch();
        t_battery();
        t_powerup("after battery");
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule